// File: doc/BRIEF.md
# Unbuffered Serial Frame Data Port

This block is a test-mode, bit-serial path between an external controller and the bit-level stream of a packet radio's baseband. It does not use the buffered FIFOs. Instead it exposes a single data pin, a direction control for that pin, and a data clock that the block generates from the system clock with an integer divider. Each bit period lasts `2*HALF_DIV` system cycles. With `HALF_DIV` set to the system frequency divided by 500 kHz, the bit period is 4 µs.

In transmit, the block first sends its own synchronisation header to the modem side. The header is `PRE_BYTES` zero bytes followed by the delimiter byte 0xA7, least-significant bit first. The data clock stays silent while the header goes out. After the header, the clock runs: the controller changes the pin while the clock is low, and the block captures the pin at each rising edge and forwards that bit to the modem. Transmit continues until the enable is removed.

In receive, the block hunts the incoming modem bits for the delimiter and keeps the clock silent until it finds it. After that, it presents each received bit on the pin while the clock is low and raises the clock once per bit. A frame-sync output marks the part of a frame after the delimiter in both directions.

Top module: `serial_frame_port`

## Requirements
- R1: While reset is asserted and right after it is released, `dataClk`, `dataOe`, `modemTxValid` and `frameSync` are all 0.
- R2: When transmit starts, the modem side receives first `8*PRE_BYTES` zero bits and then the delimiter 0xA7 least-significant bit first (1,1,1,0,0,1,0,1). One bit is sent every `2*HALF_DIV` cycles, and `modemTxValid` is a one-cycle pulse for each bit.
- R3: `dataClk` stays 0 during the whole transmit header, and in receive until the delimiter is found.
- R4: After the header, `dataClk` is high for `HALF_DIV` cycles in each bit period. The block captures `dataIn` at the clock edge where `dataClk` goes high and sends the captured bits to the modem in order, directly after the header.
- R5: Transmit continues past any frame boundary for as long as `txEnable` is 1. Dropping `txEnable` brings `dataClk` low within two cycles and stops modem bits. Raising it again starts a new header.
- R6: A delimiter is recognised only when 0xA7 (least-significant bit first) directly follows at least `RX_MIN_ZEROS` zero bits. `frameSync` then rises in the cycle after the one in which the last delimiter bit is offered with `modemRxValid`.
- R7: After the delimiter, each modem bit appears on `dataOut` once, in arrival order, with exactly one rising `dataClk` edge. `dataOut` does not change while `dataClk` is high.
- R8: Dropping `rxEnable` returns `dataClk` and `frameSync` to 0 and the search to hunting. A later frame needs a new preamble and delimiter.
- R9: `dataOe` is 1 while receive is active and 0 while transmit is active or both modes are off.
- R10: When both enables are 1, transmit wins: the header is sent and `dataOe` is 0.
- R11: In transmit, `frameSync` becomes 1 together with the valid pulse of the last header bit and stays 1 for the payload.
- R12: A receive bit that arrives in the same cycle as the falling-clock phase is neither lost nor repeated on `dataOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Serial transmit mode select |
| rxEnable | input | 1 | Serial receive mode select |
| dataIn | input | 1 | Data pin as driven by the controller |
| dataOut | output | 1 | Data pin value driven by the block in receive |
| dataOe | output | 1 | 1 when the block drives the data pin |
| dataClk | output | 1 | Generated data clock, gated by frame sync |
| modemTxBit | output | 1 | Bit towards the modulator |
| modemTxValid | output | 1 | One-cycle strobe for `modemTxBit` |
| modemRxBit | input | 1 | Bit from the demodulator |
| modemRxValid | input | 1 | One-cycle strobe for `modemRxBit` |
| frameSync | output | 1 | High after the delimiter was sent or found |

## Verification
In receive, a demodulated bit can arrive in the same cycle as the block's falling-clock phase. In that cycle the block must both present the previous bit on the pin and store the new one. The bench provokes this by running full receive frames with the phase between enabling receive and starting the modem stream swept over every cycle of a bit period, so one of the runs lands exactly on the coincidence. Each run is judged by comparing the bits captured at every rising `dataClk` with the payload sent, both in count and in order, so a dropped or repeated bit shows up as a mismatch.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_HDR,
    ST_TX_PAY,
    ST_RX_HUNT,
    ST_RX_DATA
  } portState_t;

  // strobes and qualifiers handed from control to datapath each cycle
  typedef struct packed {
    logic rise;     // last cycle of the low half of a bit period
    logic fall;     // last cycle of a bit period
    logic silence;  // force the data clock low
    logic txHdr;    // sending the hardware header
    logic txPay;    // sending controller bits
    logic rxHunt;   // searching for the delimiter
    logic rxData;   // forwarding received bits
    logic hdrBit;   // header bit for the current bit period
  } portStb_t;

endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
#(
  parameter int          HALF_DIV  = 4,
  parameter int          PRE_BYTES = 4,
  parameter logic [7:0]  SFD_BYTE  = 8'hA7
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     txEnable,
  input  logic     rxEnable,
  input  logic     sfdHit,
  output portStb_t stb,
  output logic     frameSync,
  output logic     rxActive
);

  localparam int PERIOD   = 2 * HALF_DIV;
  localparam int CNT_W    = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int PRE_BITS = 8 * PRE_BYTES;
  localparam int HDR_BITS = PRE_BITS + 8;
  localparam int HDR_W    = $clog2(HDR_BITS);

  portState_t       state, stateNext;
  logic [CNT_W-1:0] phaseCnt;
  logic [HDR_W-1:0] hdrIdx;
  logic [HDR_W-1:0] sfdPos;
  logic             active, riseNow, fallNow, hdrLast, hdrBitNow;

  assign active  = (state != ST_IDLE);
  assign riseNow = active && (phaseCnt == CNT_W'(HALF_DIV - 1));
  assign fallNow = active && (phaseCnt == CNT_W'(PERIOD - 1));
  assign hdrLast = (hdrIdx == HDR_W'(HDR_BITS - 1));

  // bit-period divider, parked at zero while both modes are off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        phaseCnt <= '0;
    else if (!active) phaseCnt <= '0;
    else if (fallNow) phaseCnt <= '0;
    else              phaseCnt <= phaseCnt + 1'b1;
  end

  // transmit takes priority; any mode change restarts the chosen mode
  always_comb begin
    stateNext = state;
    if (txEnable) begin
      if (state == ST_IDLE || state == ST_RX_HUNT || state == ST_RX_DATA)
        stateNext = ST_TX_HDR;
      else if (state == ST_TX_HDR && fallNow && hdrLast)
        stateNext = ST_TX_PAY;
    end else if (rxEnable) begin
      if (state == ST_IDLE || state == ST_TX_HDR || state == ST_TX_PAY)
        stateNext = ST_RX_HUNT;
      else if (state == ST_RX_HUNT && sfdHit)
        stateNext = ST_RX_DATA;
    end else begin
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  hdrIdx <= '0;
    else if (state != ST_TX_HDR) hdrIdx <= '0;
    else if (fallNow)           hdrIdx <= hdrIdx + 1'b1;
  end

  // header bit: zeros for the preamble, then the delimiter LSB first
  assign sfdPos    = hdrIdx - HDR_W'(PRE_BITS);
  assign hdrBitNow = (hdrIdx < HDR_W'(PRE_BITS)) ? 1'b0
                                                  : |(SFD_BYTE & (8'd1 << sfdPos));

  assign stb.rise    = riseNow;
  assign stb.fall    = fallNow;
  assign stb.silence = (state == ST_IDLE) || (state == ST_TX_HDR) || (state == ST_RX_HUNT);
  assign stb.txHdr   = (state == ST_TX_HDR);
  assign stb.txPay   = (state == ST_TX_PAY);
  assign stb.rxHunt  = (state == ST_RX_HUNT);
  assign stb.rxData  = (state == ST_RX_DATA);
  assign stb.hdrBit  = hdrBitNow;

  assign frameSync = (state == ST_TX_PAY) || (state == ST_RX_DATA);
  assign rxActive  = (state == ST_RX_HUNT) || (state == ST_RX_DATA);

endmodule

// File: rtl/sfp_datapath.sv
module sfp_datapath
  import sfp_pkg::*;
#(
  parameter int         RX_MIN_ZEROS = 8,
  parameter logic [7:0] SFD_BYTE     = 8'hA7
) (
  input  logic     clk,
  input  logic     rstN,
  input  portStb_t stb,
  input  logic     dataIn,
  input  logic     modemRxBit,
  input  logic     modemRxValid,
  output logic     sfdHit,
  output logic     dataClk,
  output logic     dataOut,
  output logic     modemTxBit,
  output logic     modemTxValid
);

  localparam int             WIN   = RX_MIN_ZEROS + 8;
  localparam logic [WIN-1:0] MATCH = {SFD_BYTE, {RX_MIN_ZEROS{1'b0}}};

  logic [WIN-1:0] rxWin, rxWinNext;
  logic           txSample;
  logic           rxHold, rxPend, bitLoaded;

  // newest bit enters at the top, so the delimiter sits in the upper byte
  assign rxWinNext = {modemRxBit, rxWin[WIN-1:1]};
  assign sfdHit    = stb.rxHunt && modemRxValid && (rxWinNext == MATCH);

  // window restarts as all ones so a preamble must really be received
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxWin <= '1;
    else if (!stb.rxHunt)  rxWin <= '1;
    else if (modemRxValid) rxWin <= rxWinNext;
  end

  // transmit: capture the pin at the rising clock, emit at the period end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSample     <= 1'b0;
      modemTxBit   <= 1'b0;
      modemTxValid <= 1'b0;
    end else begin
      if (stb.txPay && stb.rise) txSample <= dataIn;
      modemTxValid <= stb.fall && (stb.txHdr || stb.txPay);
      if (stb.fall && stb.txHdr)      modemTxBit <= stb.hdrBit;
      else if (stb.fall && stb.txPay) modemTxBit <= txSample;
    end
  end

  // receive: one-bit hold, drained onto the pin at each falling phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold    <= 1'b0;
      rxPend    <= 1'b0;
      bitLoaded <= 1'b0;
      dataOut   <= 1'b0;
    end else if (!stb.rxData) begin
      rxPend    <= 1'b0;
      bitLoaded <= 1'b0;
    end else begin
      if (modemRxValid) begin
        rxHold <= modemRxBit;
        rxPend <= 1'b1;
      end else if (stb.fall) begin
        rxPend <= 1'b0;
      end
      if (stb.fall) begin
        bitLoaded <= rxPend;
        if (rxPend) dataOut <= rxHold;
      end
    end
  end

  // gated data clock: rises only when a bit is ready for the edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataClk <= 1'b0;
    else if (stb.silence) dataClk <= 1'b0;
    else if (stb.rise && (stb.txPay || (stb.rxData && bitLoaded)))
                          dataClk <= 1'b1;
    else if (stb.fall)    dataClk <= 1'b0;
  end

endmodule

// File: rtl/serial_frame_port.sv
module serial_frame_port
  import sfp_pkg::*;
#(
  parameter int         HALF_DIV     = 4,
  parameter int         PRE_BYTES    = 4,
  parameter int         RX_MIN_ZEROS = 8,
  parameter logic [7:0] SFD_BYTE     = 8'hA7
) (
  input  logic clk,
  input  logic rstN,
  input  logic txEnable,
  input  logic rxEnable,
  input  logic dataIn,
  output logic dataOut,
  output logic dataOe,
  output logic dataClk,
  output logic modemTxBit,
  output logic modemTxValid,
  input  logic modemRxBit,
  input  logic modemRxValid,
  output logic frameSync
);

  portStb_t stb;
  logic     sfdHit;
  logic     rxActive;

  sfp_ctrl #(
    .HALF_DIV (HALF_DIV),
    .PRE_BYTES(PRE_BYTES),
    .SFD_BYTE (SFD_BYTE)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txEnable (txEnable),
    .rxEnable (rxEnable),
    .sfdHit   (sfdHit),
    .stb      (stb),
    .frameSync(frameSync),
    .rxActive (rxActive)
  );

  sfp_datapath #(
    .RX_MIN_ZEROS(RX_MIN_ZEROS),
    .SFD_BYTE    (SFD_BYTE)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .dataIn      (dataIn),
    .modemRxBit  (modemRxBit),
    .modemRxValid(modemRxValid),
    .sfdHit      (sfdHit),
    .dataClk     (dataClk),
    .dataOut     (dataOut),
    .modemTxBit  (modemTxBit),
    .modemTxValid(modemTxValid)
  );

  assign dataOe = rxActive;

endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic dataOut,
  input logic dataOe,
  input logic dataClk,
  input logic modemTxValid,
  input logic frameSync
);

  int hiLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hiLen <= 0;
    else if (dataClk) hiLen <= hiLen + 1;
    else              hiLen <= 0;
  end

  // R1: outputs quiet on the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!dataClk && !dataOe && !modemTxValid && !frameSync));

  // R3: no clock while no frame is synchronised
  p_clk_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && !$past(frameSync)) |-> !dataClk);

  // R2: each modem transmit strobe lasts one cycle
  p_tx_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    modemTxValid |=> !modemTxValid);

  // R4: high phase of the clock lasts HALF_DIV cycles within a frame
  p_clk_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dataClk) && frameSync) |-> (hiLen == HALF_DIV));

  // R7: pin data holds while the clock is high
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataClk && $past(dataClk)) |-> $stable(dataOut));

  // R10: transmit request releases the pin
  p_tx_oe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(txEnable) |-> !dataOe);

endmodule

bind serial_frame_port sfp_checker #(.HALF_DIV(HALF_DIV)) i_sfpChecker (
  .clk         (clk),
  .rstN        (rstN),
  .txEnable    (txEnable),
  .dataOut     (dataOut),
  .dataOe      (dataOe),
  .dataClk     (dataClk),
  .modemTxValid(modemTxValid),
  .frameSync   (frameSync)
);

// File: tb/test_serial_frame_port.sv
module test_serial_frame_port;

  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 4;
  localparam int         BIT        = 2 * HALF;
  localparam int         PRE        = 4;
  localparam int         MINZ       = 8;
  localparam logic [7:0] SFD        = 8'hA7;
  localparam int         HDR        = 8 * (PRE + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic txEnable = 1'b0, rxEnable = 1'b0, dataIn = 1'b0;
  logic modemRxBit = 1'b0, modemRxValid = 1'b0;
  logic dataOut, dataOe, dataClk, modemTxBit, modemTxValid, frameSync;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_frame_port #(
    .HALF_DIV(HALF), .PRE_BYTES(PRE), .RX_MIN_ZEROS(MINZ), .SFD_BYTE(SFD)
  ) i_serial_frame_port (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rxEnable(rxEnable),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .dataClk(dataClk),
    .modemTxBit(modemTxBit), .modemTxValid(modemTxValid),
    .modemRxBit(modemRxBit), .modemRxValid(modemRxValid), .frameSync(frameSync)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit hdrExp(input int i);
    return (i < 8 * PRE) ? 1'b0 : SFD[i - 8 * PRE];
  endfunction

  task automatic runTx(input int nPay, input bit withRx);
    bit pay[64];
    bit got[128];
    int gotN = 0, rises = 0, guard = 0, hiCnt = 0, lastV = -1;
    int hdrClk = 0, oeBad = 0, widthBad = 0, spaceBad = 0, extra = 0;
    bit prevClk = 1'b0;
    for (int i = 0; i < nPay; i++) pay[i] = 1'($urandom());
    @(negedge clk);
    rxEnable = withRx;
    dataIn   = pay[0];
    txEnable = 1'b1;
    while (gotN < HDR + nPay && guard < (HDR + nPay + 4) * BIT) begin
      @(negedge clk);
      guard++;
      if (modemTxValid) begin
        got[gotN] = modemTxBit;
        check(frameSync == (gotN >= HDR - 1), "R11", "frameSync at tx bit",
              int'(frameSync), int'(gotN >= HDR - 1));
        if (lastV >= 0 && guard - lastV != BIT) spaceBad++;
        lastV = guard;
        gotN++;
      end
      if (dataClk && gotN < HDR) hdrClk++;
      if (dataOe) oeBad++;
      if (dataClk) hiCnt++;
      if (dataClk && !prevClk) rises++;
      if (!dataClk && prevClk) begin
        if (hiCnt != HALF) widthBad++;
        hiCnt = 0;
        if (rises < nPay) dataIn = pay[rises];
      end
      prevClk = dataClk;
    end
    check(gotN == HDR + nPay, "R2", "tx bit count", gotN, HDR + nPay);
    check(spaceBad == 0, "R2", "tx bit spacing errors", spaceBad, 0);
    check(hdrClk == 0, "R3", "clock cycles during header", hdrClk, 0);
    check(widthBad == 0, "R4", "clock high width errors", widthBad, 0);
    check(oeBad == 0, withRx ? "R10" : "R9", "dataOe during tx", oeBad, 0);
    for (int i = 0; i < HDR; i++)
      check(got[i] == hdrExp(i), "R2", $sformatf("header bit %0d", i),
            int'(got[i]), int'(hdrExp(i)));
    for (int k = 0; k < nPay; k++)
      check(got[HDR + k] == pay[k], "R4", $sformatf("payload bit %0d", k),
            int'(got[HDR + k]), int'(pay[k]));
    // still sending after the controller's last bit
    for (int c = 0; c < 5 * BIT; c++) begin
      @(negedge clk);
      if (modemTxValid) extra++;
    end
    check(extra >= 4, "R5", "tx keeps running", extra, 5);
    txEnable = 1'b0;
    rxEnable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(dataClk == 1'b0, "R5", "clock after tx off", int'(dataClk), 0);
    check(frameSync == 1'b0, "R5", "frameSync after tx off", int'(frameSync), 0);
    extra = 0;
    for (int c = 0; c < 3 * BIT; c++) begin
      @(negedge clk);
      if (modemTxValid) extra++;
    end
    check(extra == 0, "R5", "modem bits after tx off", extra, 0);
  endtask

  task automatic runRx(input int offset, input int nZeros, input logic [7:0] sfdSent,
                       input int nPay, input bit expectHit, input string tag);
    bit strm[128];
    bit pay[32];
    bit cap[64];
    int len = 0, idx = 0, capN = 0, sfdLast = 0, cyc = 0, tail = 0, hitCyc = -1;
    int early = 0, holdBad = 0;
    bit prevClk = 1'b0, prevOut = 1'b0;
    for (int i = 0; i < 5; i++) strm[len++] = (i == 4) ? 1'b1 : 1'($urandom());
    for (int i = 0; i < nZeros; i++) strm[len++] = 1'b0;
    for (int i = 0; i < 8; i++) strm[len++] = sfdSent[i];
    sfdLast = len - 1;
    for (int i = 0; i < nPay; i++) begin
      pay[i] = expectHit ? 1'($urandom()) : 1'b1;
      strm[len++] = pay[i];
    end
    @(negedge clk);
    txEnable = 1'b0;
    rxEnable = 1'b1;
    @(negedge clk);
    check(dataOe == 1'b1, "R9", "dataOe in rx", int'(dataOe), 1);
    repeat (offset) @(negedge clk);
    while (tail < 3 * BIT) begin
      @(negedge clk);
      if (hitCyc >= 0 && cyc == hitCyc + 1)
        check(frameSync == expectHit, tag, "frameSync after delimiter",
              int'(frameSync), int'(expectHit));
      else if (!expectHit || hitCyc < 0) begin
        if (frameSync || dataClk) early++;
      end
      if (dataClk && !prevClk && capN < 64) cap[capN++] = dataOut;
      if (dataClk && prevClk && dataOut != prevOut) holdBad++;
      prevClk = dataClk;
      prevOut = dataOut;
      if (idx < len && cyc % BIT == 0) begin
        modemRxValid = 1'b1;
        modemRxBit   = strm[idx];
        if (idx == sfdLast) hitCyc = cyc;
        idx++;
      end else begin
        modemRxValid = 1'b0;
        if (idx >= len) tail++;
      end
      cyc++;
    end
    check(early == 0, "R3", "clock or sync before delimiter", early, 0);
    check(holdBad == 0, "R7", "dataOut moved while clock high", holdBad, 0);
    check(capN == (expectHit ? nPay : 0), expectHit ? "R12" : tag,
          "rx clock edge count", capN, expectHit ? nPay : 0);
    if (expectHit)
      for (int k = 0; k < nPay; k++)
        check(cap[k] == pay[k], "R7/R12", $sformatf("rx bit %0d offset %0d", k, offset),
              int'(cap[k]), int'(pay[k]));
    rxEnable = 1'b0;
    modemRxValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(dataClk == 1'b0, "R8", "clock after rx off", int'(dataClk), 0);
    check(frameSync == 1'b0, "R8", "frameSync after rx off", int'(frameSync), 0);
    check(dataOe == 1'b0, "R9", "dataOe idle", int'(dataOe), 0);
  endtask

  initial begin
    void'($urandom(32'd2417));
    repeat (4) @(negedge clk);
    check(dataClk == 0 && dataOe == 0 && modemTxValid == 0 && frameSync == 0,
          "R1", "outputs in reset", int'({dataClk, dataOe, modemTxValid, frameSync}), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dataClk == 0 && dataOe == 0 && modemTxValid == 0 && frameSync == 0,
          "R1", "outputs after reset", int'({dataClk, dataOe, modemTxValid, frameSync}), 0);

    runTx(16, 1'b0);
    runTx(12, 1'b0);          // R5: second frame gets a fresh header
    runTx(8, 1'b1);           // R10: both enables set
    for (int off = 0; off < BIT; off++)
      runRx(off, 32, SFD, 10 + int'($urandom_range(0, 8)), 1'b1, "R6");
    runRx(3, MINZ, SFD, 10, 1'b1, "R6");        // exactly the minimum preamble
    runRx(3, MINZ - 1, SFD, 10, 1'b0, "R6");    // one zero short
    runRx(5, 16, 8'hA6, 10, 1'b0, "R6");        // wrong delimiter
    runRx(2, 0, SFD, 10, 1'b0, "R8");           // fresh hunt needs a preamble
    for (int n = 0; n < 3; n++) runTx(int'($urandom_range(1, 20)), 1'(n == 1));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog all: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule